// File: doc/BRIEF.md
# Programmable Skew Bank Generator

This block drives one bank of two clock outputs from a slow reference clock. It runs on a fast timing clock whose period is one skew unit (tU) and samples the reference on that clock. It then places the reference edges on the outputs at a fixed nominal delay, plus or minus a whole number of skew units. Because the nominal zero position sits a fixed number of timing cycles behind the sampled edge, an output can lead the nominal position as well as lag it.

Two select inputs each carry a three-level code. Together they choose one of nine configurations. A parameter sets the bank type. A standard bank steps from -4 to +4 units in single units. A doubled-step bank steps from -6 to +6 units in steps of two, and its two extreme codes give a clock divided by two or by four. A polarity input chooses whether the rising or the falling reference edge is the active edge.

Top module: `skew_bank`

## Requirements
- R1: After a reset both outputs are low, and the configuration in force is MID/MID (zero skew, undivided).
- R2: Each select carries a level code: 2'b00 is LOW, 2'b01 is MID, 2'b10 is HIGH, and 2'b11 is taken as MID. The configuration index is 3*level(sel_hi) + level(sel_lo), with LOW=0, MID=1 and HIGH=2.
- R3: On a standard bank (DOUBLE_STEP=0) the skew is k = index - 4 units, which covers -4 to +4.
- R4: On a doubled-step bank (DOUBLE_STEP=1), indices 1 to 7 give a skew of k = 2*(index - 4) units, which covers -6 to +6.
- R5: On a doubled-step bank, index 0 (LOW/LOW) outputs the active-level waveform divided by 2, and index 8 (HIGH/HIGH) outputs it divided by 4. Both divided outputs have zero skew.
- R6: When pol is 1 the active-level waveform equals the sampled reference. When pol is 0 it is the inverted reference, so the falling reference edge becomes the active edge.
- R7: The divide-by-2 signal toggles on every active edge. The divide-by-4 signal toggles on every second active edge, namely when divide-by-2 falls.
- R8: A change of either select takes effect only at the next active edge. Between active edges the configuration in force does not change.
- R9: q_a and q_b are always equal.
- R10: A change of the reference that is first sampled at timing-clock edge n appears on the outputs at edge n + NOM_DELAY + k. With MID/MID (k=0) this is exactly NOM_DELAY cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one period per skew unit |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference clock, sampled on clk |
| pol | input | 1 | Active-edge polarity: 1 rising, 0 falling |
| sel_hi | input | 2 | Upper three-level select code |
| sel_lo | input | 2 | Lower three-level select code |
| q_a | output | 1 | Bank output A |
| q_b | output | 1 | Bank output B |

## Verification
A wrong tap index, a misplaced delay stage or a wrong decode entry moves every output edge by a whole number of cycles. This shows up on the ports at the first reference edge after the configuration is loaded, at most 2*NOM_DELAY cycles later. A divider that is out of phase, or a configuration register that loads between active edges, gives an output waveform of the wrong length or phase within one or two reference periods. For these reasons the bench compares both outputs of a standard bank and a doubled-step bank against a behavioural model on every cycle. It sweeps all nine codes, both polarities, the open-pin code and rapid select changes.

// File: rtl/skew_bank_pkg.sv
// Package: shared types and select-code helpers for the skew bank.
// Assumes select codes are 2-bit encodings of a three-level input.
package skew_bank_pkg;

    // Source that feeds the delay line.
    typedef enum logic [1:0] {
        SRC_WAVE = 2'd0,
        SRC_DIV2 = 2'd1,
        SRC_DIV4 = 2'd2
    } src_sel_e;

    // Map a 2-bit code to a level: LOW=0, MID=1 (also for 2'b11), HIGH=2.
    function automatic int level_of(input logic [1:0] code);
        case (code)
            2'b00:   return 0;
            2'b10:   return 2;
            default: return 1;
        endcase
    endfunction

    // Configuration index 0..8 from the two selects.
    function automatic int code_index(input logic [1:0] hi, input logic [1:0] lo);
        return level_of(hi) * 3 + level_of(lo);
    endfunction

endpackage

// File: rtl/skew_edge_gen.sv
// Module: skew_edge_gen
// Samples the reference, forms the active-level waveform from the polarity,
// flags active edges and runs the divide-by-2 and divide-by-4 toggles.
// Assumes ref_in is slow compared with clk; its metastability is handled upstream.
module skew_edge_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic pol,
    output logic wave,
    output logic div2,
    output logic div4,
    output logic act
);

    logic wave_next;

    // Active-level waveform before the register; inverted when pol is low.
    assign wave_next = pol ? ref_in : ~ref_in;
    // An active edge is a low-to-high transition of the active-level waveform.
    assign act = wave_next & ~wave;

    // Waveform register and the two dividers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
            div2 <= 1'b0;
            div4 <= 1'b0;
        end else begin
            wave <= wave_next;
            div2 <= div2 ^ act;
            div4 <= div4 ^ (act & div2);
        end
    end

    AST_DIV2_ON_ACTIVE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (div2 != $past(div2)) |-> (wave && !$past(wave)))
        else $error("div2 moved without an active edge"); // R7

    AST_DIV4_EVERY_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (div4 != $past(div4)) |-> ($past(div2) && !div2))
        else $error("div4 moved without div2 falling"); // R7

endmodule

// File: rtl/skew_sel_decode.sv
// Module: skew_sel_decode
// Decodes the two three-level selects into a tap delay and a source choice.
// The result is registered only on an active edge.
// Assumes NOM_DELAY is at least the largest lead of the chosen table.
module skew_sel_decode
    import skew_bank_pkg::*;
#(
    parameter int NOM_DELAY   = 6,
    parameter bit DOUBLE_STEP = 1'b0,
    parameter int DW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [1:0]    sel_hi,
    input  logic [1:0]    sel_lo,
    output logic [DW-1:0] delay,
    output src_sel_e      mode
);

    localparam int CENTER = 4;

    int       idx;
    int       next_delay;
    src_sel_e next_mode;

    // Table lookup: turn the index into a delay and a source.
    always_comb begin
        idx        = code_index(sel_hi, sel_lo);
        next_mode  = SRC_WAVE;
        next_delay = NOM_DELAY + idx - CENTER;
        if (DOUBLE_STEP) begin
            next_delay = NOM_DELAY + 2 * (idx - CENTER);
            if (idx == 0) begin
                next_mode  = SRC_DIV2;
                next_delay = NOM_DELAY;
            end else if (idx == 2 * CENTER) begin
                next_mode  = SRC_DIV4;
                next_delay = NOM_DELAY;
            end
        end
    end

    // Configuration register, loaded only at an active edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay <= DW'(NOM_DELAY);
            mode  <= SRC_WAVE;
        end else if (load) begin
            delay <= DW'(next_delay);
            mode  <= next_mode;
        end
    end

    AST_SEL_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(delay) && $stable(mode)))
        else $error("configuration changed between active edges"); // R8

    AST_DIVIDED_AT_ZERO_SKEW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != SRC_WAVE) |-> (delay == DW'(NOM_DELAY)))
        else $error("divided output not at nominal delay"); // R5

endmodule

// File: rtl/skew_tap_line.sv
// Module: skew_tap_line
// Shift register of timing-clock stages with a selectable tap.
// Tap 0 is the undelayed source; tap i is the source from i cycles earlier.
// Assumes delay < DEPTH; larger values give a low output.
module skew_tap_line #(
    parameter int DEPTH = 13,
    parameter int DW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src,
    input  logic [DW-1:0] delay,
    output logic          tap
);

    localparam int NREG = DEPTH - 1;

    logic sh [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the source.
            always_ff @(posedge clk) begin
                if (!rst_n) sh[g] <= 1'b0;
                else        sh[g] <= src;
            end
        end else begin : g_rest
            // Later stages pass the previous stage on.
            always_ff @(posedge clk) begin
                if (!rst_n) sh[g] <= 1'b0;
                else        sh[g] <= sh[g-1];
            end
        end
    end

    // Tap selection across the source and all stages.
    always_comb begin
        tap = 1'b0;
        if (int'(delay) == 0) tap = src;
        for (int i = 1; i < DEPTH; i++) begin
            if (int'(delay) == i) tap = sh[i-1];
        end
    end

    AST_TAP_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(tap))
        else $error("tap output unknown"); // R1

endmodule

// File: rtl/skew_bank.sv
// Module: skew_bank (top)
// One bank of two outputs that carry the same skewed or divided copy of the
// reference. The nominal zero skew is NOM_DELAY timing cycles after the
// sampled edge.
// Assumes NOM_DELAY >= 4 (standard bank) or >= 6 (doubled-step bank).
module skew_bank
    import skew_bank_pkg::*;
#(
    parameter int NOM_DELAY   = 6,
    parameter bit DOUBLE_STEP = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       pol,
    input  logic [1:0] sel_hi,
    input  logic [1:0] sel_lo,
    output logic       q_a,
    output logic       q_b
);

    localparam int DEPTH = 2 * NOM_DELAY + 1;
    localparam int DW    = $clog2(DEPTH);
    localparam int NOUT  = 2;

    logic          wave, div2, div4, act;
    logic [DW-1:0] delay;
    src_sel_e      mode;
    logic          src;
    logic          tap;
    logic [NOUT-1:0] q_pair;

    skew_edge_gen u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .pol    (pol),
        .wave   (wave),
        .div2   (div2),
        .div4   (div4),
        .act    (act)
    );

    skew_sel_decode #(
        .NOM_DELAY   (NOM_DELAY),
        .DOUBLE_STEP (DOUBLE_STEP),
        .DW          (DW)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (act),
        .sel_hi (sel_hi),
        .sel_lo (sel_lo),
        .delay  (delay),
        .mode   (mode)
    );

    // Source multiplexer: undivided waveform or one of the dividers.
    always_comb begin
        case (mode)
            SRC_DIV2: src = div2;
            SRC_DIV4: src = div4;
            default:  src = wave;
        endcase
    end

    skew_tap_line #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src),
        .delay (delay),
        .tap   (tap)
    );

    // Output pair: each driver carries the same tap.
    for (genvar g = 0; g < NOUT; g++) begin : g_out
        assign q_pair[g] = tap;
    end

    assign q_a = q_pair[0];
    assign q_b = q_pair[1];

endmodule

// File: tb/sim_skew_bank.sv
module sim_skew_bank;

    localparam int NOM = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       pol = 1'b1;
    logic [1:0] sel_hi = 2'b01;
    logic [1:0] sel_lo = 2'b01;
    logic       s_a, s_b, d_a, d_b;

    always #10 clk = ~clk;

    skew_bank #(.NOM_DELAY(NOM), .DOUBLE_STEP(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .pol(pol),
        .sel_hi(sel_hi), .sel_lo(sel_lo), .q_a(s_a), .q_b(s_b));

    skew_bank #(.NOM_DELAY(NOM), .DOUBLE_STEP(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .pol(pol),
        .sel_hi(sel_hi), .sel_lo(sel_lo), .q_a(d_a), .q_b(d_b));

    int    tests = 0;
    int    fails = 0;
    int    hp = 4;
    int    rcnt = 0;
    bit    ref_run = 0;
    bit    chk_en = 0;
    bit    done = 0;
    string tag = "R1";

    // Reference generator: toggles every hp timing cycles.
    always @(negedge clk) begin
        if (ref_run) begin
            rcnt++;
            if (rcnt >= hp) begin
                rcnt = 0;
                ref_in = ~ref_in;
            end
        end
    end

    // ---------------- behavioural model ----------------
    int mt;
    bit mw, m2, m4;
    int mcfg = 4;
    bit hs [0:1][0:31];

    function automatic int lvl(input logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b10) return 2;
        return 1;
    endfunction

    function automatic logic [1:0] code_of(input int l);
        if (l == 0) return 2'b00;
        if (l == 1) return 2'b01;
        return 2'b10;
    endfunction

    function automatic int dly(input int dbl, input int idx);
        if (dbl == 0) return NOM + idx - 4;
        if (idx == 0 || idx == 8) return NOM;
        return NOM + 2 * (idx - 4);
    endfunction

    function automatic bit pick(input int dbl, input int idx, input bit w, input bit d2, input bit d4);
        if (dbl == 1 && idx == 0) return d2;
        if (dbl == 1 && idx == 8) return d4;
        return w;
    endfunction

    always @(posedge clk) begin
        bit wn;
        if (!rst_n) begin
            mt = 0; mw = 0; m2 = 0; m4 = 0; mcfg = 4;
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < 32; i++) hs[b][i] = 0;
        end else begin
            wn = pol ? ref_in : ~ref_in;
            if (wn && !mw) begin
                if (m2) m4 = ~m4;
                m2 = ~m2;
                mcfg = lvl(sel_hi) * 3 + lvl(sel_lo);
            end
            mw = wn;
            for (int b = 0; b < 2; b++) hs[b][mt % 32] = pick(b, mcfg, mw, m2, m4);
            mt++;
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual=%0b expected=%0b", req, what, $time, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            int  i;
            bit  e;
            for (int b = 0; b < 2; b++) begin
                i = mt - 1 - dly(b, mcfg);
                e = (i < 0) ? 1'b0 : hs[b][i % 32];
                if (b == 0) begin
                    check(tag, "u0 q_a", s_a, e);
                    check(tag, "u0 q_b", s_b, e);
                end else begin
                    check(tag, "u1 q_a", d_a, e);
                    check(tag, "u1 q_b", d_b, e);
                end
            end
            check("R9", "u0 pair", s_a, s_b);
            check("R9", "u1 pair", d_a, d_b);
        end
    end

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state of all outputs.
        check("R1", "u0 q_a reset", s_a, 1'b0);
        check("R1", "u0 q_b reset", s_b, 1'b0);
        check("R1", "u1 q_a reset", d_a, 1'b0);
        check("R1", "u1 q_b reset", d_b, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_en = 1;
        ref_run = 1;

        // R10 and R1: zero skew from the reset configuration, rising edge.
        tag = "R10 R1 R6";
        repeat (40) @(negedge clk);

        // Sweep all nine codes, selects change between active edges.
        tag = "R2 R3 R4 R5 R7 R8";
        hp = 7;
        for (int idx = 0; idx < 9; idx++) begin
            sel_hi = code_of(idx / 3);
            sel_lo = code_of(idx % 3);
            repeat (60) @(negedge clk);
        end

        // Falling-edge polarity, including the divided modes.
        tag = "R6 R5 R7";
        pol = 1'b0;
        hp = 5;
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = (k == 0) ? 0 : (k == 1) ? 8 : (k == 2) ? 1 : 7;
            sel_hi = code_of(idx / 3);
            sel_lo = code_of(idx % 3);
            repeat (50) @(negedge clk);
        end
        pol = 1'b1;

        // Open-pin code 2'b11 behaves as MID.
        tag = "R2 R10";
        sel_hi = 2'b11; sel_lo = 2'b11;
        repeat (40) @(negedge clk);
        sel_hi = 2'b11; sel_lo = 2'b00;
        repeat (40) @(negedge clk);

        // Rapid select changes: only active edges may load them.
        tag = "R8 R3 R4";
        hp = 9;
        for (int k = 0; k < 20; k++) begin
            int idx;
            idx = (k * 5) % 9;
            sel_hi = code_of(idx / 3);
            sel_lo = code_of(idx % 3);
            repeat (4) @(negedge clk);
        end
        repeat (30) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

endmodule